// File: doc/BRIEF.md
# Bitmap Fetch Address Sequencer

This block produces the read addresses for a raster bitmap. While it runs, it issues one memory read per clock cycle. Each returned byte goes to a video bus, where it stands for 8 high-resolution pixels or 4 multicolour pixels. A 16-bit pointer supplies the address. After each fetch the pointer moves by a programmable signed step. On the last fetch of a display line it also moves by a programmable signed padding.

With these two values the same hardware can produce several layouts:

- plain sequential bitmaps;
- mirrored lines, using a negative step;
- repeated lines, using a padding equal to minus the line length;
- one line per 256-byte page, using a padding of 256 minus the width.

A small byte-wide CPU write port programs the start address, step, padding and line length. Each of these values is written as a low byte and then a high byte. A control register starts and stops the sequencer. The memory behind the block is a synchronous read port with one cycle of latency.

Top module: `bmp_addr_seq`

## Requirements
- R1: After reset `mem_rd`, `vid_valid` and `vid_data` are 0, and the sequencer stays idle until the control register is written.
- R2: Writing the control register (select 0) with bit 0 set starts the sequencer, or restarts it if it is already running. From the next cycle `mem_rd` is 1, `mem_addr` equals the committed start address, and the fetch counter is reloaded.
- R3: While running, for a fetch that is not the last of its line, the next address is the current address plus the step, modulo 2^16. The step is a two's-complement value, so negative steps walk backwards.
- R4: On the last fetch of a line, the next address is the current address plus the step plus the padding, modulo 2^16. A padding of 0 continues at the next byte. A padding of minus the line length repeats the line. A padding of 256 minus the width skips to the next 256-byte page.
- R5: Each 16-bit value is committed only when its high byte is written, taking the most recently written low byte. A low-byte write alone never changes the value in use.
- R6: Writing the control register with bit 0 clear stops fetching. `mem_rd` is 0 from the next cycle.
- R7: The byte returned for a fetch appears on `vid_data` with `vid_valid` high in the cycle after that fetch. `vid_data` is 0 whenever `vid_valid` is low.
- R8: A line length of N means N fetches per line. A length of 0 behaves as 1, so every fetch is the last of its line.
- R9: A configuration value committed while running is used from the first pointer advance after the commit edge, without restarting the sequence.
- R10: Register select codes: 0 is the control register. Start address is 1 (low) and 2 (high). Step is 3 and 4. Padding is 5 and 6. Line length is 7 and 8. Other codes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_sel | input | 4 | Register select |
| cpu_wdata | input | 8 | Register write data |
| mem_rd | output | 1 | Memory read strobe, high while running |
| mem_addr | output | 16 | Memory read address (0 while idle) |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| vid_valid | output | 1 | Video byte valid |
| vid_data | output | 8 | Video byte, 0 when not valid |

## Verification
The bench goes after the line-end transition:

- A design that applies only the padding would drift one byte per line, and the line-repeat case would break.
- A design that drops the padding would never skip to the next page.
- A design that mishandles a length of 0 or 1 would stall or run a line too long.

It also writes lone low bytes in the middle of a run. A design that commits on the low byte would show a torn step at once.

Finally, it restarts while running and stops the sequencer. This exposes a pointer that fails to reload, and video bytes that leak while idle or land a cycle early or late.

// File: rtl/bas_pkg.sv
package bas_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int N_WREG = 4;
    localparam int SEL_W  = 4;

    // word register indices
    localparam int IDX_START = 0;
    localparam int IDX_STEP  = 1;
    localparam int IDX_PAD   = 2;
    localparam int IDX_LEN   = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL = '0;
endpackage

// File: rtl/bas_regs.sv
module bas_regs
    import bas_pkg::*;
#(
    parameter int BW   = BYTE_W,
    parameter int NREG = N_WREG,
    parameter int SW   = SEL_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [SW-1:0]                 sel_i,
    input  logic [BW-1:0]                 wdata_i,
    output logic [NREG-1:0][2*BW-1:0]     word_o,
    output logic                          ctrl_wr_o,
    output logic                          ctrl_en_o
);
    typedef struct packed {
        logic [NREG-1:0][BW-1:0]   stage;
        logic [NREG-1:0][2*BW-1:0] word;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            for (int i = 0; i < NREG; i++) begin
                if (sel_i == SW'(2*i + 1)) st_d.stage[i] = wdata_i;
                if (sel_i == SW'(2*i + 2)) st_d.word[i]  = {wdata_i, st_q.stage[i]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o    = st_q.word;
    assign ctrl_wr_o = we_i && (sel_i == SW'(0));
    assign ctrl_en_o = wdata_i[0];

    // a lone low-byte write never alters a committed value
    p_no_tear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i[0] && sel_i <= SW'(2*NREG)) |=> $stable(st_q.word));
endmodule

// File: rtl/bas_walker.sv
module bas_walker
    import bas_pkg::*;
#(
    parameter int AW = WORD_W,
    parameter int LW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] start_i,
    input  logic [AW-1:0] step_i,
    input  logic [AW-1:0] pad_i,
    input  logic [LW-1:0] len_i,
    input  logic          ctrl_wr_i,
    input  logic          ctrl_en_i,
    output logic          run_o,
    output logic [AW-1:0] ptr_o
);
    typedef struct packed {
        logic          run;
        logic [AW-1:0] ptr;
        logic [LW-1:0] cnt;
    } walk_t;

    walk_t st_d, st_q;
    logic [LW-1:0] reload;
    logic          line_end;

    assign reload   = (len_i == '0) ? '0 : len_i - LW'(1);
    assign line_end = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (st_q.run) begin
            if (line_end) begin
                st_d.ptr = st_q.ptr + step_i + pad_i;
                st_d.cnt = reload;
            end else begin
                st_d.ptr = st_q.ptr + step_i;
                st_d.cnt = st_q.cnt - LW'(1);
            end
        end
        if (ctrl_wr_i) begin
            if (ctrl_en_i) begin
                st_d.run = 1'b1;
                st_d.ptr = start_i;
                st_d.cnt = reload;
            end else begin
                st_d.run = 1'b0;
                st_d.ptr = st_q.ptr;
                st_d.cnt = st_q.cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o = st_q.run;
    assign ptr_o = st_q.ptr;

    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && ctrl_en_i) |=> (st_q.run && st_q.ptr == $past(start_i)));
    p_mid_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !ctrl_wr_i && !line_end) |=> (st_q.ptr == $past(st_q.ptr + step_i)));
    p_line_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !ctrl_wr_i && line_end) |=>
            (st_q.ptr == $past(st_q.ptr + step_i + pad_i)));
    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && !ctrl_en_i) |=> !st_q.run);
endmodule

// File: rtl/bas_vidout.sv
module bas_vidout
    import bas_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_i,
    input  logic [DW-1:0] rdata_i,
    output logic          valid_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        logic valid;
    } vid_t;

    vid_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign data_o  = st_q.valid ? rdata_i : '0;

    p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> valid_o);
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> (data_o == '0));
endmodule

// File: rtl/bmp_addr_seq.sv
module bmp_addr_seq
    import bas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [SEL_W-1:0]  cpu_sel,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic              mem_rd,
    output logic [WORD_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              vid_valid,
    output logic [BYTE_W-1:0] vid_data
);
    logic [N_WREG-1:0][WORD_W-1:0] words;
    logic                          ctrl_wr, ctrl_en;
    logic                          run;
    logic [WORD_W-1:0]             ptr;

    bas_regs #(.BW(BYTE_W), .NREG(N_WREG), .SW(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(cpu_we), .sel_i(cpu_sel),
        .wdata_i(cpu_wdata), .word_o(words),
        .ctrl_wr_o(ctrl_wr), .ctrl_en_o(ctrl_en)
    );

    bas_walker #(.AW(WORD_W), .LW(WORD_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .start_i(words[IDX_START]), .step_i(words[IDX_STEP]),
        .pad_i(words[IDX_PAD]), .len_i(words[IDX_LEN]),
        .ctrl_wr_i(ctrl_wr), .ctrl_en_i(ctrl_en),
        .run_o(run), .ptr_o(ptr)
    );

    bas_vidout #(.DW(BYTE_W)) u_vid (
        .clk(clk), .rst_n(rst_n), .rd_i(run), .rdata_i(mem_rdata),
        .valid_o(vid_valid), .data_o(vid_data)
    );

    assign mem_rd   = run;
    assign mem_addr = run ? ptr : '0;

    p_idle_out_r1: assert property (@(posedge clk) $past(!rst_n) |-> (!mem_rd && !vid_valid));
endmodule

// File: tb/bmp_addr_seq_test.sv
module bmp_addr_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [3:0]  cpu_sel = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        vid_valid;
    logic [7:0]  vid_data;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";
    bit    done = 1'b0;

    always #10 clk = ~clk;

    bmp_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .vid_valid(vid_valid), .vid_data(vid_data)
    );

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // synchronous memory model
    always @(posedge clk) if (mem_rd) mem_rdata <= mem_f(mem_addr);

    // behavioural model built from the requirements
    logic [15:0] m_word [4];
    logic [7:0]  m_stage [4];
    logic        m_run;
    logic [15:0] m_ptr;
    logic [15:0] m_cnt;

    function automatic logic [15:0] m_reload();
        return (m_word[3] == 0) ? 16'd0 : m_word[3] - 16'd1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_ptr = 0; m_cnt = 0;
            for (int i = 0; i < 4; i++) begin m_word[i] = 0; m_stage[i] = 0; end
        end else begin
            if (m_run) begin
                if (m_cnt == 0) begin
                    m_ptr = m_ptr + m_word[1] + m_word[2];
                    m_cnt = m_reload();
                end else begin
                    m_ptr = m_ptr + m_word[1];
                    m_cnt = m_cnt - 1;
                end
            end
            if (cpu_we) begin
                if (cpu_sel == 0) begin
                    if (cpu_wdata[0]) begin
                        m_run = 1; m_ptr = m_word[0]; m_cnt = m_reload();
                    end else m_run = 0;
                end else if (cpu_sel <= 8) begin
                    if (cpu_sel[0]) m_stage[(cpu_sel - 1) / 2] = cpu_wdata;
                    else m_word[(cpu_sel - 2) / 2] = {cpu_wdata, m_stage[(cpu_sel - 2) / 2]};
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // scoreboard: expected video bytes
    logic [7:0] exp_q [$];

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (vid_valid) begin
                if (exp_q.size() == 0) check("R7", {24'd0, vid_data}, 32'hDEAD);
                else check("R7", {24'd0, vid_data}, {24'd0, exp_q.pop_front()});
            end else begin
                check("R7", {24'd0, vid_data}, 32'd0);
            end
            check(tag, {31'd0, mem_rd}, {31'd0, m_run});
            if (m_run) begin
                check(tag, {16'd0, mem_addr}, {16'd0, m_ptr});
                exp_q.push_back(mem_f(m_ptr));
            end
        end
    end

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1; cpu_sel = s; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 0;
    endtask

    task automatic wr16(input int idx, input logic [15:0] v);
        wr(4'(2*idx + 1), v[7:0]);
        wr(4'(2*idx + 2), v[15:8]);
    endtask

    task automatic setup(input logic [15:0] s, input logic [15:0] st,
                         input logic [15:0] p, input logic [15:0] l);
        wr(0, 8'h00);
        wr16(0, s); wr16(1, st); wr16(2, p); wr16(3, l);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1", {30'd0, mem_rd, vid_valid}, 32'd0);
        check("R1", {24'd0, vid_data}, 32'd0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        tag = "R1";

        // R2 R3 R4: sequential, padding 0
        tag = "R4"; setup(16'h1000, 16'd1, 16'd0, 16'd4);
        tag = "R2"; wr(0, 8'h01);
        tag = "R3"; repeat (18) @(negedge clk);

        // mirrored lines with negative step
        tag = "R4"; setup(16'h2003, 16'hFFFF, 16'd8, 16'd4);
        tag = "R3"; wr(0, 8'h01);
        repeat (17) @(negedge clk);

        // repeat line: padding = -length
        tag = "R4"; setup(16'h0FFE, 16'd1, 16'hFFFD, 16'd3);
        wr(0, 8'h01);
        repeat (15) @(negedge clk);

        // one line per 256-byte page
        setup(16'h30F0, 16'd1, 16'h00FB, 16'd5);
        wr(0, 8'h01);
        repeat (22) @(negedge clk);

        // R8: length 0 behaves as 1
        tag = "R8"; setup(16'h4000, 16'd2, 16'h0010, 16'd0);
        wr(0, 8'h01);
        repeat (8) @(negedge clk);
        tag = "R8"; wr16(3, 16'd1);
        repeat (6) @(negedge clk);

        // R5: lone low-byte write while running, commit later
        tag = "R5"; setup(16'h5000, 16'd1, 16'd0, 16'd6);
        wr(0, 8'h01);
        repeat (3) @(negedge clk);
        wr(3, 8'h04);
        repeat (6) @(negedge clk);
        tag = "R9"; wr(4, 8'h00);
        repeat (8) @(negedge clk);
        wr16(2, 16'h0100);
        repeat (10) @(negedge clk);

        // R2: restart while running
        tag = "R2"; wr(0, 8'h01);
        repeat (5) @(negedge clk);

        // R10: unused select code is ignored
        tag = "R10"; wr(4'hF, 8'hAA);
        repeat (5) @(negedge clk);

        // R6: stop
        tag = "R6"; wr(0, 8'h00);
        repeat (2) @(negedge clk);
        check("R6", {31'd0, mem_rd}, 32'd0);
        check("R6", {31'd0, vid_valid}, 32'd0);
        check("R6", {24'd0, vid_data}, 32'd0);
        repeat (4) @(negedge clk);

        done = 1;
        check("R7", exp_q.size(), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule